// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

This block is one general-purpose I/O port of parameterised width (eight pins by default). Each pin has its own configuration bits: direction, output level, reduced drive, pull enable, a shared select bit and interrupt enable. The block turns those bits into the pad controls for each pin: output enable, output value, drive-strength select, pull-up enable and pull-down enable. A plain synchronous write port and a combinational read port, both fed from flops, give access to the registers.

The select bit has two jobs. While the pull is active it chooses between a pull-up and a pull-down. It also sets which edge raises an interrupt. Every pad input passes through a two-flop synchronizer. The block compares each synchronized value with its value one clock earlier. An edge of the selected polarity sets a sticky flag if that pin's interrupt is enabled, and this works even when the pin drives as an output. The interrupt request is the OR of all enabled flags. A build-time parameter removes interrupt capability from the port.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every configuration register and every flag is 0. All pins are then inputs with no pull, and the interrupt request is low.
- R2: The register addresses are 0 direction, 1 output level, 2 reduced drive, 3 pull enable, 4 select, 5 interrupt enable, 6 flags and 7 pin state. Addresses 0 to 5 read back the value last written. A write to address 7 has no effect.
- R3: A pin with direction bit 1 has its output enable high and drives its output-level bit. With direction bit 0 the output enable and the output value are both 0.
- R4: The drive-strength select is high only for an output pin whose reduced-drive bit is 1. On an input pin the reduced-drive bit has no effect.
- R5: The pull-up enable is high only for an input pin with pull enable 1 and select 0. The pull-down enable needs an input pin, pull enable 1 and select 1. Both are low on an output pin.
- R6: Reads of address 7 return the pad inputs through a two-flop synchronizer. A pad change shows there after two clock edges and not after one.
- R7: With interrupt enable 1, select 0 flags falling edges and select 1 flags rising edges. This holds whatever the pull-enable and direction bits are. With interrupt enable 0 no flag is set.
- R8: Flags are sticky. Writing 1 to a bit of address 6 clears that flag, and writing 0 leaves it unchanged. An edge in the same cycle as its clear leaves the flag set.
- R9: The interrupt request is high exactly when some flag is set and that pin's interrupt enable is 1.
- R10: When the port is built without interrupt capability, addresses 5 and 6 read 0 and the interrupt request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | WIDTH | Read data, taken from flops |
| pad_in | input | WIDTH | Asynchronous pad inputs |
| pad_oe | output | WIDTH | Output enable per pin |
| pad_out | output | WIDTH | Output value per pin |
| pad_rdrv | output | WIDTH | Reduced-drive select per pin |
| pull_up_en | output | WIDTH | Pull-up enable per pin |
| pull_dn_en | output | WIDTH | Pull-down enable per pin |
| irq | output | 1 | OR of enabled flags |

## Verification
The assertions check on every cycle that no pin gets both pulls or any pull while it drives, and that reduced drive never shows on an input pin. They also check that a flag never rises on a pin whose interrupt was disabled, and that the request stays low while no flag is enabled. Edge polarity, the synchronizer latency, the set-over-clear priority, sticky behaviour and the register map appear only in the bench's scenarios. Those scenarios also cover a pin that is an output but still gets flagged, and the port built without interrupt capability.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        REG_DIR = 3'd0,
        REG_LVL = 3'd1,
        REG_DRV = 3'd2,
        REG_PEN = 3'd3,
        REG_SEL = 3'd4,
        REG_IEN = 3'd5,
        REG_FLG = 3'd6,
        REG_PIN = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] sel_i,
    input  logic [WIDTH-1:0] ien_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] flag;
    } irq_t;

    irq_t st_d, st_q;
    logic [WIDTH-1:0] rise, fall, hit;

    always_comb begin
        rise      = pin_i & ~st_q.prev;
        fall      = ~pin_i & st_q.prev;
        hit       = ien_i & ((sel_i & rise) | (~sel_i & fall));
        st_d      = st_q;
        st_d.prev = pin_i;
        st_d.flag = (st_q.flag & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = |(st_q.flag & ien_i);

    // R7
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.flag & ~$past(st_q.flag) & ~$past(ien_i)) == '0));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_i == '0) |-> !irq_o);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
    parameter int WIDTH   = 8,
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_rdrv,
    output logic [WIDTH-1:0] pull_up_en,
    output logic [WIDTH-1:0] pull_dn_en,
    output logic             irq
);
    import gpio_pkg::*;

    localparam logic [WIDTH-1:0] IEN_MASK = HAS_IRQ ? {WIDTH{1'b1}} : '0;

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lvl;
        logic [WIDTH-1:0] drv;
        logic [WIDTH-1:0] pen;
        logic [WIDTH-1:0] sel;
        logic [WIDTH-1:0] ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [WIDTH-1:0] pin_sync, flags, clr;
    logic             irq_int;
    reg_addr_e        waddr, raddr;

    assign waddr = reg_addr_e'(wr_addr);
    assign raddr = reg_addr_e'(rd_addr);

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (wr_en) begin
            unique case (waddr)
                REG_DIR: cfg_d.dir = wr_data;
                REG_LVL: cfg_d.lvl = wr_data;
                REG_DRV: cfg_d.drv = wr_data;
                REG_PEN: cfg_d.pen = wr_data;
                REG_SEL: cfg_d.sel = wr_data;
                REG_IEN: cfg_d.ien = wr_data & IEN_MASK;
                REG_FLG: clr       = wr_data;
                REG_PIN: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pad_in),
        .sync_o (pin_sync)
    );

    generate
        if (HAS_IRQ) begin : g_irq
            gpio_irq_unit #(.WIDTH(WIDTH)) u_irq (
                .clk   (clk),
                .rst_n (rst_n),
                .pin_i (pin_sync),
                .sel_i (cfg_q.sel),
                .ien_i (cfg_q.ien),
                .clr_i (clr),
                .flag_o(flags),
                .irq_o (irq_int)
            );
        end else begin : g_noirq
            assign flags   = '0;
            assign irq_int = 1'b0;
        end
    endgenerate

    assign pad_oe     = cfg_q.dir;
    assign pad_out    = cfg_q.dir & cfg_q.lvl;
    assign pad_rdrv   = cfg_q.dir & cfg_q.drv;
    assign pull_up_en = ~cfg_q.dir & cfg_q.pen & ~cfg_q.sel;
    assign pull_dn_en = ~cfg_q.dir & cfg_q.pen & cfg_q.sel;
    assign irq        = irq_int;

    always_comb begin
        unique case (raddr)
            REG_DIR: rd_data = cfg_q.dir;
            REG_LVL: rd_data = cfg_q.lvl;
            REG_DRV: rd_data = cfg_q.drv;
            REG_PEN: rd_data = cfg_q.pen;
            REG_SEL: rd_data = cfg_q.sel;
            REG_IEN: rd_data = cfg_q.ien;
            REG_FLG: rd_data = flags;
            REG_PIN: rd_data = pin_sync;
        endcase
    end

    // R5
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up_en & pull_dn_en) == '0));

    // R5
    no_pull_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pull_up_en | pull_dn_en) & pad_oe) == '0));

    // R4
    rdrv_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_rdrv & ~pad_oe) == '0));

    // R10
    noirq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_IRQ |-> (!irq && flags == '0));
endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] rd_data, pad_oe, pad_out, pad_rdrv, pull_up_en, pull_dn_en;
    logic         irq;
    logic [W-1:0] rd_data_n, oe_n, out_n, rdrv_n, pu_n, pd_n;
    logic         irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_port #(.WIDTH(W), .HAS_IRQ(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_rdrv(pad_rdrv), .pull_up_en(pull_up_en),
        .pull_dn_en(pull_dn_en), .irq(irq)
    );

    gpio_edge_port #(.WIDTH(W), .HAS_IRQ(1'b0)) u_dut_noirq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_n),
        .pad_in(pad_in), .pad_oe(oe_n), .pad_out(out_n),
        .pad_rdrv(rdrv_n), .pull_up_en(pu_n),
        .pull_dn_en(pd_n), .irq(irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d, l, r, p, s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pad_oe === '0 && pad_out === '0 && pad_rdrv === '0, "R1 pad", pad_oe, 0);
        check(pull_up_en === '0 && pull_dn_en === '0, "R1 pull", pull_up_en | pull_dn_en, 0);
        check(irq === 1'b0, "R1 irq", irq, 0);
        for (int a = 0; a < 7; a++) rd_check(3'(a), '0, "R1 regs");

        // R2 readback, R3 R4 R5 pad outputs over a sweep
        for (int n = 0; n < 64; n++) begin
            d = 8'(n * 37); l = 8'(n * 91 + 5); r = 8'(n * 53 + 3);
            p = 8'(n * 29 + 7); s = 8'(n * 71 + 1);
            wr(3'd0, d); wr(3'd1, l); wr(3'd2, r); wr(3'd3, p); wr(3'd4, s);
            #1;
            check(pad_oe === d && pad_out === (d & l), "R3 drive", pad_out, d & l);
            check(pad_rdrv === (d & r), "R4 rdrv", pad_rdrv, d & r);
            check(pull_up_en === (~d & p & ~s), "R5 pullup", pull_up_en, ~d & p & ~s);
            check(pull_dn_en === (~d & p & s), "R5 pulldown", pull_dn_en, ~d & p & s);
            rd_check(3'd0, d, "R2 dir");
            rd_check(3'd1, l, "R2 lvl");
            rd_check(3'd2, r, "R2 drv");
            rd_check(3'd3, p, "R2 pen");
            rd_check(3'd4, s, "R2 sel");
        end

        // R6 synchronizer latency; R2 write to pin register ignored
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);
        settle(3);
        pad_in = 8'hA5;
        @(posedge clk);
        rd_check(3'd7, 8'h00, "R6 one edge");
        @(posedge clk);
        rd_check(3'd7, 8'hA5, "R6 two edges");
        wr(3'd7, 8'h3C);
        rd_check(3'd7, 8'hA5, "R2 pin write ignored");
        pad_in = 8'h00;
        settle(4);

        // R7 polarity, pins as outputs with pull enable set
        wr(3'd0, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h0F); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
        rd_check(3'd5, 8'hFF, "R2 ien");
        rd_check(3'd6, 8'h00, "R8 clear start");
        pad_in = 8'hFF;
        settle(4);
        rd_check(3'd6, 8'h0F, "R7 rising");
        check(irq === 1'b1, "R9 irq on", irq, 1);
        // R8 sticky then partial clear
        settle(5);
        rd_check(3'd6, 8'h0F, "R8 sticky");
        wr(3'd6, 8'h05);
        rd_check(3'd6, 8'h0A, "R8 partial clear");
        wr(3'd6, 8'hFF);
        rd_check(3'd6, 8'h00, "R8 clear");
        check(irq === 1'b0, "R9 irq off", irq, 0);
        pad_in = 8'h00;
        settle(4);
        rd_check(3'd6, 8'hF0, "R7 falling");
        // R9 mask: disabling interrupt keeps flag, drops request
        wr(3'd5, 8'h0F);
        check(irq === 1'b0, "R9 masked", irq, 0);
        rd_check(3'd6, 8'hF0, "R9 flag kept");
        wr(3'd6, 8'hFF);

        // R7 disabled pins never flag
        pad_in = 8'hFF;
        settle(4);
        rd_check(3'd6, 8'h0F, "R7 disabled pins");
        wr(3'd6, 8'hFF);
        wr(3'd5, 8'h00);
        pad_in = 8'h00;
        settle(4);
        rd_check(3'd6, 8'h00, "R7 ien zero");
        check(irq === 1'b0, "R9 no enable", irq, 0);

        // R8 set wins over same-cycle clear (pin 0 falling edge)
        wr(3'd4, 8'h00); wr(3'd5, 8'h01);
        pad_in = 8'h01;
        settle(4);
        @(negedge clk);
        pad_in = 8'h00;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h01;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rd_check(3'd6, 8'h01, "R8 set wins");
        wr(3'd6, 8'h01);
        rd_check(3'd6, 8'h00, "R8 clear no edge");

        // R10 port without interrupt capability
        wr(3'd5, 8'hFF);
        pad_in = 8'hFF;
        settle(4);
        @(negedge clk);
        rd_addr = 3'd5; #1;
        check(rd_data_n === 8'h00, "R10 ien reads 0", rd_data_n, 0);
        rd_addr = 3'd6; #1;
        check(rd_data_n === 8'h00, "R10 flags read 0", rd_data_n, 0);
        check(irq_n === 1'b0, "R10 irq low", irq_n, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule